// File: doc/BRIEF.md
# Segment and Port Output Selector

This block sits between the latched display image of a small LCD driver and its analog output stage. Every output pin gets a 2-bit level code: low, mid or high. There are 54 segment pins. The lowest four of them are shared pins that can also act as general-purpose outputs. There are also two common pins. The frame generator supplies the instantaneous level for each of the four possible segment patterns and for each common electrode. The selector works out which pattern each pin shows in the current drive mode, and then applies the override controls. Those controls are the active-low display inhibit, the power-save bit and the segments-off bit. A legacy compatibility flag pins down a few outputs and neutralises some of the controls.

The decision logic is combinational, and the results are captured in one output register. Every output therefore reflects the inputs presented at the previous rising clock edge. Asynchronous reset clears all outputs to the low code.

Top module: `segport_selector`

## Requirements
- R1: While `rst_n` is low, every pin code and both common codes are 2'b00 (low).
- R2: Static mode (`duplexMode`=0): segment pin n (1-based) shows the segment waveform entry selected by index {0, D(n)}, where D(k) is `dispData[k-1]` and the entry for index j is `segWave[2j+1:2j]`.
- R3: Duplex mode (`duplexMode`=1): segment pin n shows the entry selected by index {D(2n), D(2n-1)}. Bit 0 of the index is the common-1 dot and bit 1 is the common-2 dot.
- R4: The 3-bit `portSel` makes shared pins ports cumulatively. The value k in 0..4 turns pins 1..k into ports. The values 5..7 make no pin a port.
- R5: A port pin outputs 2'b10 (high) when its data bit is 1 and 2'b00 when it is 0. The data bit of port pin k is D(k) in static mode and D(2k-1) in duplex mode.
- R6: With `inhibitN` low, all pins and both commons output low and no pin acts as a port. This takes priority over everything else.
- R7: With `powerSave`=1 (outside compatibility mode), segment pins and commons output low, while port pins keep following their data.
- R8: With `segOff`=1 (outside compatibility mode and power-save), every segment pin shows waveform entry 0 (the off pattern).
- R9: With `compatMode`=1, no shared pin acts as a port, segment pin 24 outputs low, and `powerSave` and `segOff` have no effect.
- R10: With `compatMode`=1 in duplex mode, segment pin 54 shows waveform entry 3 (the all-on pattern).
- R11: Common 1 follows `com1Wave`. Common 2 follows `com2Wave` only in duplex mode and is low in static mode. Both commons are low under inhibit or power-save.
- R12: Code 2'b11 is never output. A waveform input of 2'b11 that would be passed through is output as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibitN | input | 1 | Display inhibit, active low |
| duplexMode | input | 1 | 0 static drive, 1 two-common drive |
| powerSave | input | 1 | Power-save control bit |
| segOff | input | 1 | Segments-off control bit |
| compatMode | input | 1 | Legacy compatibility transfer flag |
| portSel | input | 3 | Shared pin port select field |
| dispData | input | 108 | Latched display bits, D1 at bit 0 |
| segWave | input | 8 | Level code per segment pattern index 0..3 |
| com1Wave | input | 2 | Level code for common 1 |
| com2Wave | input | 2 | Level code for common 2 |
| pinLevel | output | 108 | Level code of pin n at bits [2n-1:2n-2] |
| com1Level | output | 2 | Level code of common 1 |
| com2Level | output | 2 | Level code of common 2 |

## Verification
The bench builds the selector with its default values of 54 segment pins and 4 shared pins. This brings the two fixed compatibility pins, 24 and 54, into reach, along with the last duplex data pair (D107, D108). With 4 shared pins, all five legal port-select values and the three out-of-range ones can be exercised, including the stride-two data source in duplex mode. Directed vectors cover each override in isolation and in pairs that test priority. Randomised vectors then mix modes, control bits and waveform codes, including the reserved code.

// File: rtl/segsel_pkg.sv
package segsel_pkg;
  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_LOW  = 2'b00;
  localparam lvl_t LVL_MID  = 2'b01;
  localparam lvl_t LVL_HIGH = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic duplex;      // two-common drive
    logic segLow;      // force segment pins low
    logic segBlank;    // show off pattern on segment pins
    logic comLow;      // force commons low
    logic com2On;      // common 2 follows its waveform
    logic compatHold;  // hold the fixed compat pin low
    logic allOnLast;   // last pin shows all-on pattern
  } strobe_t;

  function automatic lvl_t cleanLvl(input lvl_t c);
    return (c == 2'b11) ? LVL_LOW : c;
  endfunction
endpackage

// File: rtl/segsel_ctrl.sv
module segsel_ctrl
  import segsel_pkg::*;
#(
  parameter int NUM_SHARED = 4,
  parameter int PSEL_W     = 3
) (
  input  logic                  inhibitN,
  input  logic                  duplexMode,
  input  logic                  powerSave,
  input  logic                  segOff,
  input  logic                  compatMode,
  input  logic [PSEL_W-1:0]     portSel,
  output strobe_t               strobes,
  output logic [NUM_SHARED-1:0] portMask
);
  logic forced, effPs, effOff, selLegal;

  always_comb begin
    forced   = ~inhibitN;
    effPs    = powerSave & ~compatMode;
    effOff   = segOff & ~compatMode;
    selLegal = int'(portSel) <= NUM_SHARED;

    strobes.duplex     = duplexMode;
    strobes.segLow     = forced | effPs;
    strobes.segBlank   = effOff;
    strobes.comLow     = forced | effPs;
    strobes.com2On     = duplexMode & ~(forced | effPs);
    strobes.compatHold = compatMode;
    strobes.allOnLast  = compatMode & duplexMode;

    for (int k = 0; k < NUM_SHARED; k++) begin
      portMask[k] = ~forced & ~compatMode & selLegal & (int'(portSel) > k);
    end
  end
endmodule

// File: rtl/segsel_dp.sv
module segsel_dp
  import segsel_pkg::*;
#(
  parameter int NUM_SEG    = 54,
  parameter int NUM_SHARED = 4,
  parameter int HOLD_PIN   = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  strobe_t                 strobes,
  input  logic [NUM_SHARED-1:0]   portMask,
  input  logic [2*NUM_SEG-1:0]    dispData,
  input  logic [7:0]              segWave,
  input  lvl_t                    com1Wave,
  input  lvl_t                    com2Wave,
  output logic [2*NUM_SEG-1:0]    pinLevel,
  output lvl_t                    com1Level,
  output lvl_t                    com2Level
);
  lvl_t pinNext [NUM_SEG];
  lvl_t com1Next, com2Next;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_pin
    logic bitA, bitB;
    lvl_t segNext;

    always_comb begin
      bitA = strobes.duplex ? dispData[2*i]   : dispData[i];
      bitB = strobes.duplex ? dispData[2*i+1] : 1'b0;
      if (strobes.segLow)
        segNext = LVL_LOW;
      else if (strobes.compatHold && (i == HOLD_PIN-1))
        segNext = LVL_LOW;
      else if (strobes.allOnLast && (i == NUM_SEG-1))
        segNext = cleanLvl(segWave[7:6]);
      else if (strobes.segBlank)
        segNext = cleanLvl(segWave[1:0]);
      else
        segNext = cleanLvl(segWave[{bitB, bitA, 1'b0} +: 2]);
    end

    if (i < NUM_SHARED) begin : g_shared
      assign pinNext[i] = portMask[i] ? (bitA ? LVL_HIGH : LVL_LOW) : segNext;

      // R5
      port_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        portMask[i] |=> (pinLevel[2*i +: 2] != LVL_MID));
    end else begin : g_plain
      assign pinNext[i] = segNext;
    end

    // R12
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pinLevel[2*i +: 2] != 2'b11);
  end

  always_comb begin
    com1Next = strobes.comLow ? LVL_LOW : cleanLvl(com1Wave);
    com2Next = strobes.com2On ? cleanLvl(com2Wave) : LVL_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pinLevel  <= '0;
      com1Level <= LVL_LOW;
      com2Level <= LVL_LOW;
    end else begin
      for (int i = 0; i < NUM_SEG; i++) pinLevel[2*i +: 2] <= pinNext[i];
      com1Level <= com1Next;
      com2Level <= com2Next;
    end
  end

  // R12
  com_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (com1Level != 2'b11) && (com2Level != 2'b11));
endmodule

// File: rtl/segport_selector.sv
module segport_selector
  import segsel_pkg::*;
#(
  parameter  int NUM_SEG    = 54,
  parameter  int NUM_SHARED = 4,
  parameter  int HOLD_PIN   = 24,
  localparam int PSEL_W     = $clog2(NUM_SHARED + 1),
  localparam int DATA_W     = 2 * NUM_SEG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inhibitN,
  input  logic              duplexMode,
  input  logic              powerSave,
  input  logic              segOff,
  input  logic              compatMode,
  input  logic [PSEL_W-1:0] portSel,
  input  logic [DATA_W-1:0] dispData,
  input  logic [7:0]        segWave,
  input  logic [1:0]        com1Wave,
  input  logic [1:0]        com2Wave,
  output logic [DATA_W-1:0] pinLevel,
  output logic [1:0]        com1Level,
  output logic [1:0]        com2Level
);
  strobe_t               strobes;
  logic [NUM_SHARED-1:0] portMask;

  segsel_ctrl #(.NUM_SHARED(NUM_SHARED), .PSEL_W(PSEL_W)) u_ctrl (
    .inhibitN(inhibitN), .duplexMode(duplexMode), .powerSave(powerSave),
    .segOff(segOff), .compatMode(compatMode), .portSel(portSel),
    .strobes(strobes), .portMask(portMask)
  );

  segsel_dp #(.NUM_SEG(NUM_SEG), .NUM_SHARED(NUM_SHARED), .HOLD_PIN(HOLD_PIN)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .portMask(portMask),
    .dispData(dispData), .segWave(segWave), .com1Wave(com1Wave),
    .com2Wave(com2Wave), .pinLevel(pinLevel), .com1Level(com1Level),
    .com2Level(com2Level)
  );

  // R6
  inhibit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibitN |=> (pinLevel == '0 && com1Level == LVL_LOW && com2Level == LVL_LOW));

  // R11
  static_com2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !duplexMode |=> com2Level == LVL_LOW);

  // R7
  ps_com_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (powerSave && !compatMode) |=> (com1Level == LVL_LOW && com2Level == LVL_LOW));

  // R9
  compat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    compatMode |=> pinLevel[2*HOLD_PIN-1 -: 2] == LVL_LOW);
endmodule

// File: tb/sim_segport_selector.sv
module sim_segport_selector;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         inhibitN = 1, duplexMode = 0, powerSave = 0, segOff = 0, compatMode = 0;
  logic [2:0]   portSel = 0;
  logic [107:0] dispData = '0;
  logic [7:0]   segWave = 8'h00;
  logic [1:0]   com1Wave = 0, com2Wave = 0;
  logic [107:0] pinLevel;
  logic [1:0]   com1Level, com2Level;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #4 clk = ~clk;

  segport_selector u0 (
    .clk(clk), .rst_n(rst_n), .inhibitN(inhibitN), .duplexMode(duplexMode),
    .powerSave(powerSave), .segOff(segOff), .compatMode(compatMode),
    .portSel(portSel), .dispData(dispData), .segWave(segWave),
    .com1Wave(com1Wave), .com2Wave(com2Wave), .pinLevel(pinLevel),
    .com1Level(com1Level), .com2Level(com2Level)
  );

  function automatic int cl(int c);
    return (c == 3) ? 0 : c;
  endfunction

  function automatic int waveAt(int j);
    return cl(int'(segWave[2*j +: 2]));
  endfunction

  function automatic int dBit(int k);  // D(k), 1-based
    return int'(dispData[k-1]);
  endfunction

  function automatic int expPin(int n);
    bit ps, off;
    int cnt, a, b;
    if (!inhibitN) return 0;
    ps  = powerSave && !compatMode;
    off = segOff && !compatMode;
    cnt = (!compatMode && portSel <= 4) ? int'(portSel) : 0;
    if (n <= cnt) return dBit(duplexMode ? 2*n-1 : n) ? 2 : 0;
    if (ps) return 0;
    if (compatMode && n == 24) return 0;
    if (compatMode && duplexMode && n == 54) return waveAt(3);
    if (off) return waveAt(0);
    a = duplexMode ? dBit(2*n-1) : dBit(n);
    b = duplexMode ? dBit(2*n) : 0;
    return waveAt(2*b + a);
  endfunction

  task automatic applyVec(string tag);
    int e1, e2, bad, badPin, badAct, badExp;
    int ePin [54];
    bit ps;
    ps = powerSave && !compatMode;
    for (int n = 1; n <= 54; n++) ePin[n-1] = expPin(n);
    e1 = (!inhibitN || ps) ? 0 : cl(int'(com1Wave));
    e2 = (!inhibitN || ps || !duplexMode) ? 0 : cl(int'(com2Wave));
    @(posedge clk);
    #1;
    vectors++;
    bad = 0;
    for (int n = 1; n <= 54; n++) begin
      if (int'(pinLevel[2*n-2 +: 2]) != ePin[n-1] && bad == 0) begin
        bad = 1; badPin = n; badAct = int'(pinLevel[2*n-2 +: 2]); badExp = ePin[n-1];
      end
    end
    if (bad) begin
      miscompares++;
      $display("FAIL %s pin %0d: got %0d expected %0d", tag, badPin, badAct, badExp);
    end else if (int'(com1Level) != e1 || int'(com2Level) != e2) begin
      miscompares++;
      $display("FAIL %s commons: got %0d/%0d expected %0d/%0d", tag,
               com1Level, com2Level, e1, e2);
    end
  endtask

  task automatic baseline();
    inhibitN = 1; duplexMode = 0; powerSave = 0; segOff = 0; compatMode = 0;
    portSel = 0; com1Wave = 2'b10; com2Wave = 2'b01;
    segWave = {2'b10, 2'b01, 2'b10, 2'b00};
  endtask

  initial begin
    logic [127:0] r;
    dispData = {27{4'b1011}};
    segWave  = 8'b10_01_10_01;
    com1Wave = 2'b10; com2Wave = 2'b10;
    repeat (3) @(posedge clk);
    #1;
    vectors++;  // R1 reset state
    if (pinLevel != '0 || com1Level != 0 || com2Level != 0) begin
      miscompares++;
      $display("FAIL R1 reset: got pins %h com %0d/%0d expected all 0",
               pinLevel, com1Level, com2Level);
    end
    @(negedge clk) rst_n = 1;

    // R2 static mapping, two patterns
    baseline(); dispData = {27{4'b0110}};            applyVec("R2");
    segWave = {2'b00, 2'b00, 2'b01, 2'b10};          applyVec("R2");
    // R3 duplex mapping, all four indices used
    baseline(); duplexMode = 1; dispData = {27{4'b1110}};
    segWave = {2'b10, 2'b01, 2'b00, 2'b01};          applyVec("R3");
    dispData = {54{2'b10}};                          applyVec("R3");
    dispData[107:106] = 2'b11; dispData[1:0] = 2'b01; applyVec("R3");
    // R4 thermometer port select, static and each value
    for (int s = 0; s < 8; s++) begin
      baseline(); dispData = {27{4'b0101}}; portSel = 3'(s); applyVec("R4");
    end
    // R5 duplex stride two for port data
    baseline(); duplexMode = 1; portSel = 4;
    dispData = '0; dispData[0] = 1; dispData[4] = 1;  applyVec("R5");
    dispData = '0; dispData[2] = 1; dispData[6] = 1;  applyVec("R5");
    // R6 inhibit beats ports and everything
    baseline(); portSel = 4; dispData = '1; duplexMode = 1; inhibitN = 0; applyVec("R6");
    compatMode = 1; powerSave = 1;                   applyVec("R6");
    // R7 power-save: segments low, ports follow
    baseline(); portSel = 2; dispData = '1; powerSave = 1; applyVec("R7");
    duplexMode = 1; segOff = 1;                      applyVec("R7");
    // R8 segments off pattern
    baseline(); segOff = 1; dispData = '1; segWave = {2'b10, 2'b10, 2'b10, 2'b01}; applyVec("R8");
    duplexMode = 1; portSel = 1;                     applyVec("R8");
    // R9 compat: no ports, pin 24 low, ps and segOff ignored
    baseline(); compatMode = 1; portSel = 4; powerSave = 1; segOff = 1;
    dispData = '1; segWave = {2'b10, 2'b01, 2'b10, 2'b00}; applyVec("R9");
    // R10 compat duplex: pin 54 all-on
    duplexMode = 1; dispData = '0;                   applyVec("R10");
    // R11 commons
    baseline(); com1Wave = 2'b01; com2Wave = 2'b10;  applyVec("R11");
    duplexMode = 1;                                  applyVec("R11");
    // R12 reserved code input
    baseline(); duplexMode = 1; segWave = 8'hFF; com1Wave = 3; com2Wave = 3;
    dispData = {27{4'b1001}};                        applyVec("R12");
    segOff = 1;                                      applyVec("R12");

    for (int v = 0; v < 300; v++) begin
      r = {$urandom, $urandom, $urandom, $urandom};
      dispData   = r[107:0];
      segWave    = 8'($urandom);
      com1Wave   = 2'($urandom);
      com2Wave   = 2'($urandom);
      portSel    = 3'($urandom);
      duplexMode = 1'($urandom);
      powerSave  = ($urandom % 4) == 0;
      segOff     = ($urandom % 4) == 0;
      compatMode = ($urandom % 5) == 0;
      inhibitN   = ($urandom % 8) != 0;
      applyVec("mixed(R2)");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule